// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Control

This block steers the two source operands of the instruction in decode (ID) of a five-stage integer pipeline with full bypassing. It keeps its own record of each instruction's destination and writing behaviour as that instruction moves through execute (EX), memory access (MA) and writeback (WB). For each operand it picks a source: the register file, or the value produced by EX, MA or WB. When several stages write the register being read, the youngest of them wins. The datapath muxes, ALU and memories are outside the block.

Register results from ALU-type, upper-immediate, AUIPC and jump-and-link producers can be forwarded from EX. A load's data only exists after MA. If the instruction in ID reads the destination of a load that is still in EX, the block raises `stall`. In that cycle the PC and the IF/ID register must hold, and a bubble with writing disabled enters EX in place of the ID instruction. One cycle later the held instruction sees the load in MA and takes its data from there. The instruction class is a 4-bit code: 0 none, 1 register ALU, 2 immediate ALU, 3 load, 4 store, 5 branch, 6 load-upper-immediate, 7 add-upper-immediate-to-PC, 8 jump-and-link, 9 jump-and-link-register. Codes 10 to 15 behave as class 0.

Top module: `hzc_bypass_ctl`

## Requirements
- R1: After reset the EX, MA and WB records hold no writer. Until an instruction reaches EX, both selects read 00, `stall` is 0 and `ex_bubble` is 0, whatever is presented at ID.
- R2: A read source equal to the nonzero destination of an EX instruction of class 1, 2, 6, 7, 8 or 9 gives select 01, and `stall` stays 0.
- R3: A read source that matches only an MA writer gives select 10. One that matches only a WB writer gives select 11. An MA writer of class 3 counts as a writer here.
- R4: When several stages write the same register, the select goes to the youngest: EX first, then MA, then WB, then the register file (00).
- R5: A destination of register 0 never forwards and never stalls. A source of register 0 always selects 00.
- R6: Source 1 is read only by classes 1, 2, 3, 4, 5 and 9. Source 2 is read only by classes 1, 4 and 5. An unread source selects 00 and cannot cause a stall.
- R7: `stall` is 1 exactly when EX holds a class 3 instruction with a nonzero destination that equals a read source of the ID instruction. While `stall` is 1, both selects read 00.
- R8: The cycle after a stall, `ex_bubble` is 1 and EX holds no writer. The held instruction then does not stall again, and it takes the load data from MA (select 10). A load-use dependence therefore costs exactly one cycle.
- R9: Classes 0, 4, 5 and codes 10 to 15 never write. Whatever their destination field holds, they produce no forwarding and no stall in any later stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_cls | input | 4 | Class code of the ID instruction |
| id_rs1 | input | 5 | First source register of the ID instruction |
| id_rs2 | input | 5 | Second source register of the ID instruction |
| id_rd | input | 5 | Destination register of the ID instruction |
| sel_a | output | 2 | Operand A source: 00 file, 01 EX, 10 MA, 11 WB |
| sel_b | output | 2 | Operand B source, same encoding |
| stall | output | 1 | Hold PC and IF/ID; inject a bubble into EX |
| ex_bubble | output | 1 | EX holds a bubble injected by the previous stall |

## Verification
Forwarding selection and the load-use stall can both be in play in the same cycle. One case is a load in EX that matches operand A while an ALU producer further down matches operand B. Another is a load in EX followed by an older writer of the same register in MA. The bench builds these by issuing a load behind one or two writers of the same register. It then checks that the stall wins, with both selects at 00. In the following cycle it checks that the held instruction, with the bubble now in EX, selects the MA load data rather than the older producer.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

  typedef enum logic [3:0] {
    CLS_NONE   = 4'd0,
    CLS_ALU    = 4'd1,
    CLS_ALUI   = 4'd2,
    CLS_LOAD   = 4'd3,
    CLS_STORE  = 4'd4,
    CLS_BRANCH = 4'd5,
    CLS_LUI    = 4'd6,
    CLS_AUIPC  = 4'd7,
    CLS_JAL    = 4'd8,
    CLS_JALR   = 4'd9
  } op_cls_e;

  localparam int CLS_W = 4;

endpackage

// File: rtl/hzc_decode.sv
module hzc_decode
  import hzc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [AW-1:0]    rd,
  output logic             re1,
  output logic             re2,
  output logic             wr_en,
  output logic             byp_ok,
  output logic             ld_res
);

  logic writes;
  logic early;
  logic rd_nz;

  assign rd_nz = (rd != '0);

  // Which sources each class reads, and what kind of result it produces.
  always_comb begin
    re1    = 1'b0;
    re2    = 1'b0;
    writes = 1'b0;
    early  = 1'b0;
    case (cls)
      CLS_ALU:    begin re1 = 1'b1; re2 = 1'b1; writes = 1'b1; early = 1'b1; end
      CLS_ALUI:   begin re1 = 1'b1;             writes = 1'b1; early = 1'b1; end
      CLS_LOAD:   begin re1 = 1'b1;             writes = 1'b1;               end
      CLS_STORE:  begin re1 = 1'b1; re2 = 1'b1;                              end
      CLS_BRANCH: begin re1 = 1'b1; re2 = 1'b1;                              end
      CLS_LUI:    begin                         writes = 1'b1; early = 1'b1; end
      CLS_AUIPC:  begin                         writes = 1'b1; early = 1'b1; end
      CLS_JAL:    begin                         writes = 1'b1; early = 1'b1; end
      CLS_JALR:   begin re1 = 1'b1;             writes = 1'b1; early = 1'b1; end
      default:    begin                                                      end
    endcase
  end

  assign wr_en  = writes & rd_nz;
  assign byp_ok = writes & early & rd_nz;
  assign ld_res = writes & ~early & rd_nz;

endmodule

// File: rtl/hzc_stage_pipe.sv
module hzc_stage_pipe #(
  parameter int AW   = 5,
  parameter int NSTG = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     kill,
  input  logic [AW-1:0]            id_ws,
  input  logic                     id_we,
  input  logic                     id_byp,
  input  logic                     id_ld,
  output logic [NSTG-1:0][AW-1:0]  st_ws,
  output logic [NSTG-1:0]          st_we,
  output logic [NSTG-1:0]          st_byp,
  output logic [NSTG-1:0]          st_ld,
  output logic                     ex_bubble
);

  logic [NSTG-1:0][AW-1:0] ws_d;
  logic [NSTG-1:0]         we_d;
  logic [NSTG-1:0]         byp_d;
  logic [NSTG-1:0]         ld_d;
  logic                    bub_d;

  // Next state: the entry stage takes the ID record or a bubble, the rest shift.
  always_comb begin
    ws_d[0]  = kill ? '0   : id_ws;
    we_d[0]  = kill ? 1'b0 : id_we;
    byp_d[0] = kill ? 1'b0 : id_byp;
    ld_d[0]  = kill ? 1'b0 : id_ld;
    bub_d    = kill;
    for (int i = 1; i < NSTG; i++) begin
      ws_d[i]  = st_ws[i-1];
      we_d[i]  = st_we[i-1];
      byp_d[i] = 1'b0;
      ld_d[i]  = st_ld[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ws     <= '0;
      st_we     <= '0;
      st_byp    <= '0;
      st_ld     <= '0;
      ex_bubble <= 1'b0;
    end else begin
      st_ws     <= ws_d;
      st_we     <= we_d;
      st_byp    <= byp_d;
      st_ld     <= ld_d;
      ex_bubble <= bub_d;
    end
  end

  AST_BUBBLE_NO_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (!st_we[0] && !st_ld[0] && !st_byp[0])); // R8

  AST_KILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (ex_bubble && !st_we[0])); // R8

endmodule

// File: rtl/hzc_src_sel.sv
module hzc_src_sel #(
  parameter int AW    = 5,
  parameter int NSTG  = 3,
  parameter int SEL_W = $clog2(NSTG + 1)
) (
  input  logic [AW-1:0]            rs,
  input  logic                     re,
  input  logic                     hold,
  input  logic [NSTG-1:0][AW-1:0]  st_ws,
  input  logic [NSTG-1:0]          st_we,
  input  logic [NSTG-1:0]          st_byp,
  input  logic [NSTG-1:0]          st_ld,
  output logic [SEL_W-1:0]         sel,
  output logic                     ld_hit
);

  logic [NSTG-1:0] hit;
  logic [SEL_W-1:0] sel_raw;

  // Stage 0 may forward only results ready at the end of execute.
  genvar g;
  generate
    for (g = 0; g < NSTG; g++) begin : g_hit
      if (g == 0) begin : g_entry
        assign hit[g] = re & st_byp[g] & (rs == st_ws[g]);
      end else begin : g_later
        assign hit[g] = re & st_we[g] & (rs == st_ws[g]);
      end
    end
  endgenerate

  assign ld_hit = re & st_ld[0] & (rs == st_ws[0]);

  // Oldest first, so the youngest match is written last and wins.
  always_comb begin
    sel_raw = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (hit[i]) sel_raw = SEL_W'(i + 1);
    end
  end

  assign sel = hold ? '0 : sel_raw;

endmodule

// File: rtl/hzc_bypass_ctl.sv
module hzc_bypass_ctl
  import hzc_pkg::*;
#(
  parameter int AW   = 5,
  parameter int NSTG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       id_cls,
  input  logic [AW-1:0]    id_rs1,
  input  logic [AW-1:0]    id_rs2,
  input  logic [AW-1:0]    id_rd,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall,
  output logic             ex_bubble
);

  localparam int SEL_W = $clog2(NSTG + 1);

  logic re1, re2, id_we, id_byp, id_ld;
  logic [NSTG-1:0][AW-1:0] st_ws;
  logic [NSTG-1:0]         st_we, st_byp, st_ld;
  logic [1:0]              ld_hit;
  logic [1:0][SEL_W-1:0]   sel_v;
  logic [1:0][AW-1:0]      src_rs;
  logic [1:0]              src_re;

  hzc_decode #(.AW(AW)) u_dec (
    .cls    (id_cls),
    .rd     (id_rd),
    .re1    (re1),
    .re2    (re2),
    .wr_en  (id_we),
    .byp_ok (id_byp),
    .ld_res (id_ld)
  );

  hzc_stage_pipe #(.AW(AW), .NSTG(NSTG)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (stall),
    .id_ws     (id_rd),
    .id_we     (id_we),
    .id_byp    (id_byp),
    .id_ld     (id_ld),
    .st_ws     (st_ws),
    .st_we     (st_we),
    .st_byp    (st_byp),
    .st_ld     (st_ld),
    .ex_bubble (ex_bubble)
  );

  assign src_rs[0] = id_rs1;
  assign src_rs[1] = id_rs2;
  assign src_re[0] = re1;
  assign src_re[1] = re2;

  genvar k;
  generate
    for (k = 0; k < 2; k++) begin : g_src
      hzc_src_sel #(.AW(AW), .NSTG(NSTG), .SEL_W(SEL_W)) u_sel (
        .rs     (src_rs[k]),
        .re     (src_re[k]),
        .hold   (stall),
        .st_ws  (st_ws),
        .st_we  (st_we),
        .st_byp (st_byp),
        .st_ld  (st_ld),
        .sel    (sel_v[k]),
        .ld_hit (ld_hit[k])
      );
    end
  endgenerate

  assign stall = |ld_hit;
  assign sel_a = 2'(sel_v[0]);
  assign sel_b = 2'(sel_v[1]);

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (st_ld[0] && st_we[0] && !st_byp[0])); // R7

  AST_STALL_SELECTS_FILE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R7

  AST_BUBBLE_FOLLOWS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ex_bubble); // R8

  AST_NO_REPEAT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> !stall); // R8

  AST_ZERO_SRC_FILE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> (sel_a == 2'b00)); // R5

  AST_UNREAD_B_FILE: assert property (@(posedge clk) disable iff (!rst_n)
    !re2 |-> (sel_b == 2'b00)); // R6

endmodule

// File: tb/sim_hzc_bypass_ctl.sv
`timescale 1ns/1ps
module sim_hzc_bypass_ctl;

  logic       clk;
  logic       rst_n;
  logic [3:0] id_cls;
  logic [4:0] id_rs1, id_rs2, id_rd;
  logic [1:0] sel_a, sel_b;
  logic       stall, ex_bubble;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [3:0] NONE = 0, ALU = 1, ALUI = 2, LOAD = 3, STORE = 4,
                         BRANCH = 5, LUI = 6, AUIPC = 7, JAL = 8, JALR = 9;

  hzc_bypass_ctl u0 (
    .clk(clk), .rst_n(rst_n), .id_cls(id_cls), .id_rs1(id_rs1),
    .id_rs2(id_rs2), .id_rd(id_rd), .sel_a(sel_a), .sel_b(sel_b),
    .stall(stall), .ex_bubble(ex_bubble)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Presents an instruction at ID after a falling edge; outputs settle 1 ns later.
  task automatic issue(input logic [3:0] c, input int rd, input int r1, input int r2);
    @(negedge clk);
    id_cls = c; id_rd = 5'(rd); id_rs1 = 5'(r1); id_rs2 = 5'(r2);
    #1;
  endtask

  task automatic hold_cycle();
    @(negedge clk);
    #1;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) issue(NONE, 0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 stall", stall, 0);
    chk("R1 sel_a", sel_a, 0);
    chk("R1 sel_b", sel_b, 0);
    chk("R1 bubble", ex_bubble, 0);
    id_cls = ALU; id_rd = 3; id_rs1 = 3; id_rs2 = 3; #1;
    chk("R1 sel_a empty", sel_a, 0);
    chk("R1 sel_b empty", sel_b, 0);
  endtask

  task automatic t_alu_chain();
    flush();
    issue(ALU, 1, 2, 3);
    issue(ALU, 2, 1, 1);
    chk("R2 sel_a EX", sel_a, 1);
    chk("R2 sel_b EX", sel_b, 1);
    chk("R2 no stall", stall, 0);
    issue(ALU, 3, 2, 1);
    chk("R3 sel_a EX", sel_a, 1);
    chk("R3 sel_b MA", sel_b, 2);
    chk("R3 no stall", stall, 0);
    issue(ALU, 4, 1, 3);
    chk("R3 sel_a WB", sel_a, 3);
    chk("R3 sel_b EX", sel_b, 1);
    chk("R3 no stall", stall, 0);
    flush();
    issue(JAL, 14, 0, 0);
    issue(ALUI, 15, 14, 0);
    chk("R2 jal forwards", sel_a, 1);
    flush();
    issue(AUIPC, 16, 0, 0);
    issue(BRANCH, 0, 0, 16);
    chk("R2 auipc forwards", sel_b, 1);
  endtask

  task automatic t_priority();
    flush();
    issue(ALUI, 5, 0, 0);
    issue(ALUI, 5, 0, 0);
    issue(ALUI, 5, 0, 0);
    issue(ALU, 6, 5, 5);
    chk("R4 EX first a", sel_a, 1);
    chk("R4 EX first b", sel_b, 1);
    issue(ALU, 7, 5, 0);
    chk("R4 MA over WB", sel_a, 2);
    issue(ALU, 8, 5, 0);
    chk("R4 WB over file", sel_a, 3);
    issue(ALU, 9, 5, 0);
    chk("R4 file when gone", sel_a, 0);
  endtask

  task automatic t_x0();
    flush();
    issue(ALUI, 0, 1, 0);
    issue(ALU, 1, 0, 0);
    chk("R5 x0 a", sel_a, 0);
    chk("R5 x0 b", sel_b, 0);
    flush();
    issue(LOAD, 0, 1, 0);
    issue(ALU, 1, 0, 0);
    chk("R5 x0 load no stall", stall, 0);
  endtask

  task automatic t_read_en();
    flush();
    issue(ALUI, 9, 0, 0);
    issue(LUI, 10, 9, 9);
    chk("R6 lui rs1 unread", sel_a, 0);
    chk("R6 lui rs2 unread", sel_b, 0);
    issue(ALUI, 11, 9, 10);
    chk("R6 alui rs1 MA", sel_a, 2);
    chk("R6 alui rs2 unread", sel_b, 0);
    flush();
    issue(ALUI, 12, 0, 0);
    issue(STORE, 0, 0, 12);
    chk("R6 store rs2 read", sel_b, 1);
    flush();
    issue(LOAD, 13, 0, 0);
    issue(JALR, 1, 0, 13);
    chk("R6 jalr rs2 no stall", stall, 0);
  endtask

  task automatic t_load_use();
    flush();
    issue(ALUI, 1, 0, 0);
    issue(LOAD, 1, 2, 0);
    issue(ALU, 4, 1, 7);
    chk("R7 load-use stall", stall, 1);
    chk("R7 stall sel_a", sel_a, 0);
    chk("R7 stall sel_b", sel_b, 0);
    hold_cycle();
    chk("R8 one cycle only", stall, 0);
    chk("R8 bubble flag", ex_bubble, 1);
    chk("R8 MA load data", sel_a, 2);
    issue(ALU, 5, 4, 1);
    chk("R8 bubble clears", ex_bubble, 0);
    chk("R8 producer in EX", sel_a, 1);
    chk("R8 load now WB", sel_b, 3);
    flush();
    issue(LOAD, 3, 0, 0);
    issue(ALU, 5, 6, 7);
    chk("R7 independent no stall", stall, 0);
    flush();
    issue(ALUI, 8, 0, 0);
    issue(LOAD, 8, 0, 0);
    issue(STORE, 0, 8, 8);
    chk("R7 store stall", stall, 1);
    chk("R7 store stall sel_b", sel_b, 0);
    hold_cycle();
    chk("R8 store released", stall, 0);
    chk("R8 store sel_b MA", sel_b, 2);
  endtask

  task automatic t_nonwrite();
    flush();
    issue(STORE, 13, 1, 2);
    issue(ALU, 1, 13, 13);
    chk("R9 store rd EX", sel_a, 0);
    issue(BRANCH, 13, 0, 0);
    chk("R9 store rd MA", sel_b, 0);
    issue(ALU, 1, 13, 13);
    chk("R9 branch rd EX", sel_a, 0);
    chk("R9 store rd WB", sel_b, 0);
    issue(4'd12, 13, 0, 0);
    issue(ALU, 1, 13, 0);
    chk("R9 unused code", sel_a, 0);
    chk("R9 unused no stall", stall, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    id_cls = NONE; id_rd = 0; id_rs1 = 0; id_rs2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_alu_chain();
    t_priority();
    t_x0();
    t_read_en();
    t_load_use();
    t_nonwrite();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule